// File: doc/BRIEF.md
# GPIO Controller Register Bank

This block is the register side of a twelve-pin general-purpose I/O controller. A host reaches it through a plain 32-bit register bus with separate read and write strobes and a byte address. Only the word index, taken from address bits 5:2, is decoded. The bank holds the value each pin drives and whether it drives at all. It samples the pin inputs every cycle. It also keeps per-pin trigger-mode settings and a pin-use select word, and passes both to neighbouring logic.

Interrupt handling is split. A separate detector turns pin activity into one-cycle event pulses, one per pin. This bank latches those pulses into a status vector for the pins that are enabled. It applies a mask, and it raises one combined interrupt line. The mask is changed only through a set port and a clear port, each acting on the bits written as one. Status bits are cleared the same way. A soft-reset word lets software return every register to its default without the hardware reset.

Top module: `gpio_bank`

## Requirements
- R1: After the synchronous reset `rst`, every register reads zero and `irq`, `pin_out`, `pin_oe`, `trig_mode` and `rd_data` are all zero.
- R2: The output-data word (byte offset 0x18) drives `pin_out`, and the direction word (0x20) drives `pin_oe`, where 1 means drive. Both take effect the edge after the write. Only bits 11:0 are stored, and bits 31:12 read as zero.
- R3: Reading the input word (0x1C) returns `pin_in` as sampled on an edge. A value applied to `pin_in` is readable by a read issued one cycle later.
- R4: An event pulse on a pin whose bit is set in the enable word (0x00) sets that pin's status bit (read at 0x04) on the next edge. An event pulse on a pin whose enable bit is 0 leaves status unchanged.
- R5: Writing the clear port (0x0C) clears the status bits written as 1. Status bits written as 0 keep their value.
- R6: When an event and a clear hit the same status bit in the same cycle, the bit ends set.
- R7: Writing 1s to the mask-set port (0x10) sets those mask bits, and writing 1s to the mask-clear port (0x14) clears them. Bits written as 0 are unchanged. Both offsets read back the current mask.
- R8: `irq` is high exactly when some pin has status, enable and not-mask all true. The display word (0x08) reads back that per-pin vector.
- R9: Writing 1 to bit 0 of the soft-reset word (0x3C) sets it, and it reads back as 1. While it is set, writes to every other register are ignored and all state is held at its default. Writing 0 releases the bank with every register at default.
- R10: Reserved offsets (0x2C, 0x30, 0x34) and the clear port read as zero, and writes to the reserved offsets have no effect.
- R11: The mode-low word (0x24) holds 32 bits and the mode-high word (0x28) holds bits 15:0. `trig_mode` carries mode-high over mode-low, 4 bits per pin, with pin 0 in the lowest nibble. The pin-use select word (0x38) stores bits 11:0 and drives `pin_sel`.
- R12: `rd_data` carries the addressed word on the edge after a cycle with `rd_en` high, and is zero after any cycle without `rd_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| bus_addr | input | 6 | Byte address, word index in bits 5:2 |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| pin_in | input | 12 | Pin input levels |
| evt_pulse | input | 12 | Per-pin event pulses from the detector |
| pin_out | output | 12 | Output data per pin |
| pin_oe | output | 12 | Output enable per pin |
| trig_mode | output | 48 | Per-pin trigger mode, 4 bits each |
| pin_sel | output | 12 | Pin-use select |
| irq | output | 1 | Combined interrupt |

## Verification
Register writes show on `pin_out`, `pin_oe`, `trig_mode`, `pin_sel` and `irq` one edge after the write strobe. Event pulses reach status and `irq` after that same single edge. Read data arrives one edge after `rd_en`, and a pin level needs one extra edge to pass through the input sampler first. The bench changes inputs on falling edges and samples on the following falling edge, so each result is read exactly one rising edge after the stimulus that caused it. For the input word, it lets one idle cycle pass before issuing the read.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int NPINS   = 12;
    localparam int DW      = 32;
    localparam int AW      = 6;
    localparam int MODE_W  = 4;

    // word index decoded from bus_addr[5:2]; the offsets are software-visible
    typedef enum logic [3:0] {
        W_IEN   = 4'd0,
        W_STAT  = 4'd1,
        W_DISP  = 4'd2,
        W_CLR   = 4'd3,
        W_MSET  = 4'd4,
        W_MCLR  = 4'd5,
        W_OUT   = 4'd6,
        W_IN    = 4'd7,
        W_DIR   = 4'd8,
        W_MODE0 = 4'd9,
        W_MODE1 = 4'd10,
        W_SEL   = 4'd14,
        W_SRST  = 4'd15
    } reg_word_e;

    typedef struct packed {
        logic en_we;
        logic clr_we;
        logic mset_we;
        logic mclr_we;
        logic out_we;
        logic dir_we;
        logic mode0_we;
        logic mode1_we;
        logic sel_we;
    } wr_strobe_t;

    function automatic logic [DW-1:0] widen(input logic [NPINS-1:0] v);
        return {{(DW-NPINS){1'b0}}, v};
    endfunction

endpackage

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_bank_pkg::*;
#(
    parameter int N = NPINS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sclr,
    input  wr_strobe_t   strb,
    input  logic [N-1:0] wdata,
    input  logic [N-1:0] evt,
    output logic [N-1:0] en_q,
    output logic [N-1:0] mask_q,
    output logic [N-1:0] status_q,
    output logic [N-1:0] pend,
    output logic         irq
);

    logic [N-1:0] clr_bits;
    logic [N-1:0] hit;

    assign clr_bits = strb.clr_we ? wdata : '0;
    assign hit      = evt & en_q;

    always_ff @(posedge clk) begin
        if (rst || sclr) begin
            en_q     <= '0;
            mask_q   <= '0;
            status_q <= '0;
        end else begin
            if (strb.en_we)   en_q   <= wdata;
            if (strb.mset_we) mask_q <= mask_q | wdata;
            if (strb.mclr_we) mask_q <= mask_q & ~wdata;
            // new events are merged after the clear, so they win
            status_q <= (status_q & ~clr_bits) | hit;
        end
    end

    assign pend = status_q & en_q & ~mask_q;
    assign irq  = |pend;

    assert_event_sets_R4: assert property (@(posedge clk) disable iff (rst)
        (!sclr && hit != '0) |=> ((status_q & $past(hit)) == $past(hit)));

    assert_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (!sclr && strb.clr_we) |=> ((status_q & $past(wdata & ~hit)) == '0));

    assert_mask_set_R7: assert property (@(posedge clk) disable iff (rst)
        (!sclr && strb.mset_we) |=> ((mask_q & $past(wdata)) == $past(wdata)));

    assert_mask_clr_R7: assert property (@(posedge clk) disable iff (rst)
        (!sclr && strb.mclr_we) |=> ((mask_q & $past(wdata)) == '0));

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_bank_pkg::*;
#(
    parameter int N      = NPINS,
    parameter int W      = DW,
    parameter int MODE1W = (NPINS - DW / MODE_W) * MODE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclr,
    input  wr_strobe_t        strb,
    input  logic [W-1:0]      wdata,
    input  logic [N-1:0]      pin_in,
    output logic [N-1:0]      out_q,
    output logic [N-1:0]      dir_q,
    output logic [N-1:0]      in_q,
    output logic [N-1:0]      sel_q,
    output logic [W-1:0]      mode0_q,
    output logic [MODE1W-1:0] mode1_q
);

    always_ff @(posedge clk) begin
        if (rst || sclr) begin
            out_q   <= '0;
            dir_q   <= '0;
            in_q    <= '0;
            sel_q   <= '0;
            mode0_q <= '0;
            mode1_q <= '0;
        end else begin
            in_q <= pin_in;
            if (strb.out_we)   out_q   <= wdata[N-1:0];
            if (strb.dir_we)   dir_q   <= wdata[N-1:0];
            if (strb.sel_we)   sel_q   <= wdata[N-1:0];
            if (strb.mode0_we) mode0_q <= wdata;
            if (strb.mode1_we) mode1_q <= wdata[MODE1W-1:0];
        end
    end

    assert_srst_defaults_R9: assert property (@(posedge clk) disable iff (rst)
        sclr |=> (out_q == '0 && dir_q == '0 && mode0_q == '0));

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int N      = NPINS,
    parameter int W      = DW,
    parameter int A      = AW,
    parameter int MW     = MODE_W,
    parameter int MODE1W = (NPINS - DW / MODE_W) * MODE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [A-1:0]      bus_addr,
    input  logic [W-1:0]      wr_data,
    output logic [W-1:0]      rd_data,
    input  logic [N-1:0]      pin_in,
    input  logic [N-1:0]      evt_pulse,
    output logic [N-1:0]      pin_out,
    output logic [N-1:0]      pin_oe,
    output logic [N*MW-1:0]   trig_mode,
    output logic [N-1:0]      pin_sel,
    output logic              irq
);

    logic [3:0]        word;
    logic              srst_q;
    wr_strobe_t        strb;
    logic [N-1:0]      en_q, mask_q, status_q, pend, in_q;
    logic [W-1:0]      mode0_q;
    logic [MODE1W-1:0] mode1_q;
    logic [W-1:0]      rd_mux;

    assign word = bus_addr[A-1:2];

    always_comb begin
        strb = '0;
        if (wr_en && !srst_q) begin
            case (word)
                W_IEN:   strb.en_we    = 1'b1;
                W_CLR:   strb.clr_we   = 1'b1;
                W_MSET:  strb.mset_we  = 1'b1;
                W_MCLR:  strb.mclr_we  = 1'b1;
                W_OUT:   strb.out_we   = 1'b1;
                W_DIR:   strb.dir_we   = 1'b1;
                W_MODE0: strb.mode0_we = 1'b1;
                W_MODE1: strb.mode1_we = 1'b1;
                W_SEL:   strb.sel_we   = 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            srst_q <= 1'b0;
        else if (wr_en && word == W_SRST)
            srst_q <= wr_data[0];
    end

    gpio_irq_ctrl #(.N(N)) u_irq (
        .clk      (clk),
        .rst      (rst),
        .sclr     (srst_q),
        .strb     (strb),
        .wdata    (wr_data[N-1:0]),
        .evt      (evt_pulse),
        .en_q     (en_q),
        .mask_q   (mask_q),
        .status_q (status_q),
        .pend     (pend),
        .irq      (irq)
    );

    gpio_port_regs #(.N(N), .W(W), .MODE1W(MODE1W)) u_port (
        .clk     (clk),
        .rst     (rst),
        .sclr    (srst_q),
        .strb    (strb),
        .wdata   (wr_data),
        .pin_in  (pin_in),
        .out_q   (pin_out),
        .dir_q   (pin_oe),
        .in_q    (in_q),
        .sel_q   (pin_sel),
        .mode0_q (mode0_q),
        .mode1_q (mode1_q)
    );

    assign trig_mode = {mode1_q, mode0_q};

    always_comb begin
        case (word)
            W_IEN:          rd_mux = widen(en_q);
            W_STAT:         rd_mux = widen(status_q);
            W_DISP:         rd_mux = widen(pend);
            W_MSET, W_MCLR: rd_mux = widen(mask_q);
            W_OUT:          rd_mux = widen(pin_out);
            W_IN:           rd_mux = widen(in_q);
            W_DIR:          rd_mux = widen(pin_oe);
            W_MODE0:        rd_mux = mode0_q;
            W_MODE1:        rd_mux = {{(W-MODE1W){1'b0}}, mode1_q};
            W_SEL:          rd_mux = widen(pin_sel);
            W_SRST:         rd_mux = {{(W-1){1'b0}}, srst_q};
            default:        rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || !rd_en)
            rd_data <= '0;
        else
            rd_data <= rd_mux;
    end

    assert_rdata_idle_R12: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> (rd_data == '0));

    assert_masked_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '1) |-> !irq);

    assert_srst_blocks_R9: assert property (@(posedge clk) disable iff (rst)
        srst_q |=> (!irq && pin_oe == '0));

endmodule

// File: tb/gpio_bank_tb.sv
module gpio_bank_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 11;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en, rd_en;
    logic [5:0]  bus_addr;
    logic [31:0] wr_data, rd_data;
    logic [11:0] pin_in, evt_pulse, pin_out, pin_oe, pin_sel;
    logic [47:0] trig_mode;
    logic        irq;

    int n_run = 0;
    int n_fail = 0;
    logic done = 1'b0;

    // write address, write data, expected readback, requirement number
    localparam logic [5:0]  T_ADDR [NV] = '{6'h00, 6'h18, 6'h20, 6'h24, 6'h28,
                                            6'h38, 6'h10, 6'h14, 6'h2C, 6'h34, 6'h10};
    localparam logic [31:0] T_WD   [NV] = '{32'hFFFF_FFFF, 32'hA5A5_A5A5, 32'h0000_0F0F,
                                            32'h1234_5678, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
                                            32'h0000_000F, 32'h0000_0003, 32'hFFFF_FFFF,
                                            32'hFFFF_FFFF, 32'h0000_0000};
    localparam logic [31:0] T_EXP  [NV] = '{32'h0000_0FFF, 32'h0000_05A5, 32'h0000_0F0F,
                                            32'h1234_5678, 32'h0000_FFFF, 32'h0000_0FFF,
                                            32'h0000_000F, 32'h0000_000C, 32'h0,
                                            32'h0, 32'h0000_000C};
    localparam int          T_REQ  [NV] = '{4, 2, 2, 11, 11, 11, 7, 7, 10, 10, 7};

    gpio_bank u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .bus_addr(bus_addr),
        .wr_data(wr_data), .rd_data(rd_data), .pin_in(pin_in), .evt_pulse(evt_pulse),
        .pin_out(pin_out), .pin_oe(pin_oe), .trig_mode(trig_mode), .pin_sel(pin_sel),
        .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
        wr_en = 1'b1; bus_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
        rd_en = 1'b1; bus_addr = a;
        @(negedge clk);
        d = rd_data;
        rd_en = 1'b0;
    endtask

    task automatic pulse(input logic [11:0] e);
        evt_pulse = e;
        @(negedge clk);
        evt_pulse = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        rst = 1'b1; wr_en = 0; rd_en = 0; bus_addr = '0; wr_data = '0;
        pin_in = '0; evt_pulse = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 outputs", {irq, pin_out, pin_oe, pin_sel}, '0);
        check("R1 trig_mode", trig_mode, '0);
        check("R1 rd_data", rd_data, '0);
        bus_read(6'h04, d); check("R1 status", d, 0);
        bus_read(6'h20, d); check("R1 direction", d, 0);

        // table walk: write then read back
        for (int i = 0; i < NV; i++) begin
            bus_write(T_ADDR[i], T_WD[i]);
            bus_read(T_ADDR[i], d);
            if (d !== T_EXP[i]) $display("  vector %0d R%0d", i, T_REQ[i]);
            check("table (R2 R4 R7 R10 R11)", d, T_EXP[i]);
        end

        // R2 pins follow registers
        check("R2 pin_out", pin_out, 12'h5A5);
        check("R2 pin_oe", pin_oe, 12'hF0F);
        // R11 mode and select outputs
        check("R11 trig_mode", trig_mode, 48'hFFFF_1234_5678);
        check("R11 pin_sel", pin_sel, 12'hFFF);

        // R3 input sampling
        pin_in = 12'h3C3;
        @(negedge clk);
        bus_read(6'h1C, d); check("R3 input word", d, 32'h3C3);

        // R12 idle read data
        @(negedge clk);
        check("R12 idle rd_data", rd_data, 0);

        // R4 event on enabled pin
        check("R8 irq low before event", irq, 0);
        pulse(12'h001);
        check("R8 irq after event", irq, 1);
        bus_read(6'h04, d); check("R4 status", d, 32'h001);
        bus_read(6'h08, d); check("R8 display", d, 32'h001);

        // R8 masking
        bus_write(6'h10, 32'h1);
        check("R8 irq masked", irq, 0);
        bus_read(6'h08, d); check("R8 display masked", d, 0);
        bus_read(6'h04, d); check("R8 status kept", d, 32'h001);
        bus_write(6'h14, 32'h1);
        check("R8 irq unmasked", irq, 1);

        // R5 write-one-to-clear
        bus_write(6'h0C, 32'h002);
        bus_read(6'h04, d); check("R5 zero bits keep", d, 32'h001);
        bus_write(6'h0C, 32'h001);
        bus_read(6'h04, d); check("R5 cleared", d, 0);
        check("R5 irq drops", irq, 0);
        bus_read(6'h0C, d); check("R10 clear port reads zero", d, 0);

        // R4 disabled pin ignored
        bus_write(6'h00, 32'hFFE);
        pulse(12'h001);
        bus_read(6'h04, d); check("R4 disabled pin", d, 0);
        check("R4 disabled irq", irq, 0);
        bus_write(6'h00, 32'hFFF);

        // R6 event and clear together
        wr_en = 1'b1; bus_addr = 6'h0C; wr_data = 32'h010; evt_pulse = 12'h010;
        @(negedge clk);
        wr_en = 1'b0; evt_pulse = '0;
        bus_read(6'h04, d); check("R6 event wins", d, 32'h010);
        bus_write(6'h0C, 32'h010);

        // R9 soft reset
        bus_write(6'h3C, 32'h1);
        bus_read(6'h3C, d); check("R9 reset bit reads 1", d, 1);
        bus_write(6'h18, 32'hFFF);
        check("R9 write ignored", pin_out, 0);
        bus_write(6'h3C, 32'h0);
        bus_read(6'h18, d); check("R9 out default", d, 0);
        bus_read(6'h00, d); check("R9 enable default", d, 0);
        bus_read(6'h10, d); check("R9 mask default", d, 0);
        check("R9 pins default", {pin_oe, pin_sel}, 0);
        check("R9 trig default", trig_mode, 0);
        bus_write(6'h18, 32'h00F);
        check("R9 writes resume", pin_out, 12'h00F);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule